// File: doc/BRIEF.md
# Single-Channel DAC Command and Register Controller

This block sits between a serial front end and the analog model of one digital-to-analog converter channel. Each time the front end completes a 24-bit frame it raises a one-cycle strobe with the frame word. The upper 8 bits are a command and the lower 16 bits are data. The controller decodes the command and keeps the state of the channel: a preload register, an output register that drives the converter code, a write-mode flag and two power-down selections. It also answers read commands with a 16-bit value for the front end to shift out in the next frame.

Two active-low level inputs act on the registers outside the frame flow. One is a hardware load, which copies preload to output. The other is a hardware clear, which restores the default code. Both pass through a synchronizer. A static select input chooses whether the default code is zero or midscale. The sequencer has two states. ST_IDLE waits for a frame strobe. ST_EXEC applies the captured command for one cycle. The transitions are: ST_IDLE to ST_EXEC on a strobe; ST_EXEC to ST_EXEC on a back-to-back strobe; ST_EXEC to ST_IDLE otherwise. Reset is synchronous and active low.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, the preload and output registers hold the default code, with no power-down selected. The default code is 0000h when mid_sel is 0 and 8000h when mid_sel is 1. The configuration read returns 0004h. Its layout is: bit 2 is the write-block flag, bit 1 is the 10k pull-down selection, bit 0 is the high-impedance selection, and all other bits are zero.
- R2: The command byte is frame bits 23:16 and the data is bits 15:0. The addressed commands are 00001aaa, 00010aaa, 10001aaa, 10010aaa and 10011aaa, and they act only when aaa = 000. The reserved codes 10000xxx and every unlisted code change nothing and produce no read strobe.
- R3: In write-block mode (the reset mode), command 08h loads the data into preload only, and the output code is unchanged.
- R4: Command 28h sets the mode from data bit 0. A 1 selects write-through and clears configuration bit 2. A 0 selects write-block. In write-through, command 08h loads preload and output together.
- R5: Commands 10h and 20h load preload and output together in either mode.
- R6: Command 18h with data bit 0 = 1 copies preload to output. With data bit 0 = 0 it has no effect.
- R7: While load_n is low, the output register takes the preload value on every cycle, so a new preload value reaches out_code one cycle after it is written. The input becomes effective within three clock edges of going low.
- R8: Command 01h, or clear_n held low, sets preload and output to the default code. Priority is: clear, then hardware load, then a frame update in the same cycle.
- R9: Command 30h sets power-down. Data bit 8 requests high impedance and data bit 0 requests 10k pull-down. When both are set, only pull-down is selected. When neither is set, power-down is left. Writes still update the registers during power-down.
- R10: Commands 88h, 90h and 98h return preload, configuration and output respectively on rd_data. rd_valid is raised for one cycle, one clock after the edge that samples the frame strobe. A read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | One-cycle strobe: a complete frame is present |
| frame_word | input | 24 | Command byte (23:16) and data (15:0) |
| load_n | input | 1 | Hardware load level, active low, asynchronous |
| clear_n | input | 1 | Hardware clear level, active low, asynchronous |
| mid_sel | input | 1 | Default code select: 0 = zero, 1 = midscale |
| out_code | output | 16 | Code driven to the converter |
| out_hiz | output | 1 | Output buffer in high-impedance power-down |
| out_pulldown | output | 1 | Output terminated by the 10k pull-down |
| rd_valid | output | 1 | Read value strobe |
| rd_data | output | 16 | Register value answered to a read |

## Verification
On every cycle, the assertions check the following. A held clear forces the default code. A held load copies preload to output. A write-block write leaves the output alone. A power command with the pull-down bit yields pull-down only. Reads leave both data registers stable. The read strobe follows an executed read frame. Other behaviour is shown only by the bench's scenarios against its reference model: exact opcode and address filtering, mode switching and the configuration field values, one-cycle pass-through under a held load, and the clear-over-load-over-frame priority.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SOFT_CLEAR,
        OP_SOFT_LOAD,
        OP_SET_MODE,
        OP_POWER,
        OP_WRITE,
        OP_WRITE_UPD,
        OP_WRITE_ALL,
        OP_READ_PRE,
        OP_READ_CFG,
        OP_READ_OUT
    } dac_op_t;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_EXEC
    } seq_state_t;

    function automatic logic op_is_read(dac_op_t op);
        return (op == OP_READ_PRE) || (op == OP_READ_CFG) || (op == OP_READ_OUT);
    endfunction
endpackage

// File: rtl/dac_level_sync.sv
module dac_level_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= {WIDTH{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_ctrl_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int CHAN_ID = 0
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [CODE_W-1:0] data,
    output dac_op_t           op
);
    logic addr_hit;
    logic chan_sel;

    assign addr_hit = (cmd[ADDR_W-1:0] == ADDR_W'(CHAN_ID));
    assign chan_sel = data[CHAN_ID];

    always_comb begin
        op = OP_NONE;
        unique casez (cmd)
            8'b0000_0000: op = OP_NONE;
            8'b0000_0001: op = OP_SOFT_CLEAR;
            8'b0001_1000: op = chan_sel ? OP_SOFT_LOAD : OP_NONE;
            8'b0010_1000: op = OP_SET_MODE;
            8'b0011_0000: op = OP_POWER;
            8'b0010_0000: op = OP_WRITE_ALL;
            8'b0000_1???: op = addr_hit ? OP_WRITE     : OP_NONE;
            8'b0001_0???: op = addr_hit ? OP_WRITE_UPD : OP_NONE;
            8'b1000_1???: op = addr_hit ? OP_READ_PRE  : OP_NONE;
            8'b1001_0???: op = addr_hit ? OP_READ_CFG  : OP_NONE;
            8'b1001_1???: op = addr_hit ? OP_READ_OUT  : OP_NONE;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_ctrl_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  dac_op_t           op,
    input  logic [CODE_W-1:0] data,
    input  logic              clr_lvl,
    input  logic              ld_lvl,
    input  logic              mid_sel,
    output logic [CODE_W-1:0] out_q,
    output logic              pd_hiz,
    output logic              pd_pull,
    output logic              rd_valid,
    output logic [CODE_W-1:0] rd_data
);
    localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam int                HIZ_BIT   = CODE_W / 2 + CHAN_ID;
    localparam int                PULL_BIT  = CHAN_ID;

    logic [CODE_W-1:0] pre_q;
    logic              blk_q;
    logic [CODE_W-1:0] def_code;
    logic [CODE_W-1:0] cfg_word;
    logic              soft_clr, soft_ld, pre_wr, out_wr, any_clr, any_ld;

    assign def_code = mid_sel ? MID_CODE : '0;
    assign cfg_word = {{(CODE_W-3){1'b0}}, blk_q, pd_pull, pd_hiz};

    assign soft_clr = exec_en && (op == OP_SOFT_CLEAR);
    assign soft_ld  = exec_en && (op == OP_SOFT_LOAD);
    assign pre_wr   = exec_en && ((op == OP_WRITE) || (op == OP_WRITE_UPD) || (op == OP_WRITE_ALL));
    assign out_wr   = exec_en && ((op == OP_WRITE_UPD) || (op == OP_WRITE_ALL) ||
                                  ((op == OP_WRITE) && !blk_q));
    assign any_clr  = clr_lvl || soft_clr;
    assign any_ld   = ld_lvl || soft_ld;

    // data registers: clear > load > frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= def_code;
            out_q <= def_code;
        end else begin
            if (any_clr)     pre_q <= def_code;
            else if (pre_wr) pre_q <= data;

            if (any_clr)     out_q <= def_code;
            else if (any_ld) out_q <= pre_q;
            else if (out_wr) out_q <= data;
        end
    end

    // configuration state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q   <= 1'b1;
            pd_hiz  <= 1'b0;
            pd_pull <= 1'b0;
        end else if (exec_en) begin
            if (op == OP_SET_MODE) blk_q <= !data[CHAN_ID];
            if (op == OP_POWER) begin
                pd_pull <= data[PULL_BIT];
                pd_hiz  <= data[HIZ_BIT] && !data[PULL_BIT];
            end
        end
    end

    // read reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= exec_en && op_is_read(op);
            if (exec_en) begin
                unique case (op)
                    OP_READ_PRE: rd_data <= pre_q;
                    OP_READ_CFG: rd_data <= cfg_word;
                    OP_READ_OUT: rd_data <= out_q;
                    default:     rd_data <= rd_data;
                endcase
            end
        end
    end

    assert_clear_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lvl |=> (out_q == $past(def_code)));

    assert_load_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lvl && !any_clr) |=> (out_q == $past(pre_q)));

    assert_block_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_WRITE && blk_q && !any_clr && !ld_lvl) |=> $stable(out_q));

    assert_pull_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_POWER && data[PULL_BIT]) |=> (pd_pull && !pd_hiz));

    assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_is_read(op) && !clr_lvl && !ld_lvl) |=> ($stable(pre_q) && $stable(out_q)));
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int CODE_W      = 16,
    parameter int CHAN_ID     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_valid,
    input  logic [CMD_W+CODE_W-1:0] frame_word,
    input  logic                    load_n,
    input  logic                    clear_n,
    input  logic                    mid_sel,
    output logic [CODE_W-1:0]       out_code,
    output logic                    out_hiz,
    output logic                    out_pulldown,
    output logic                    rd_valid,
    output logic [CODE_W-1:0]       rd_data
);
    localparam int FRAME_W = CMD_W + CODE_W;

    seq_state_t        state, state_nx;
    logic [CMD_W-1:0]  cmd_q;
    logic [CODE_W-1:0] data_q;
    logic              exec_en;
    dac_op_t           op;
    logic [1:0]        pins_s;
    logic              clr_lvl, ld_lvl;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = frame_valid ? ST_EXEC : ST_IDLE;
            ST_EXEC: state_nx = frame_valid ? ST_EXEC : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        exec_en = 1'b0;
        unique case (state)
            ST_IDLE: exec_en = 1'b0;
            ST_EXEC: exec_en = 1'b1;
            default: exec_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (frame_valid) begin
            cmd_q  <= frame_word[FRAME_W-1:CODE_W];
            data_q <= frame_word[CODE_W-1:0];
        end
    end

    dac_level_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clear_n, load_n}),
        .q     (pins_s)
    );
    assign clr_lvl = !pins_s[1];
    assign ld_lvl  = !pins_s[0];

    dac_cmd_decode #(.CODE_W(CODE_W), .CHAN_ID(CHAN_ID)) i_dec (
        .cmd  (cmd_q),
        .data (data_q),
        .op   (op)
    );

    dac_reg_bank #(.CODE_W(CODE_W), .CHAN_ID(CHAN_ID)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_en  (exec_en),
        .op       (op),
        .data     (data_q),
        .clr_lvl  (clr_lvl),
        .ld_lvl   (ld_lvl),
        .mid_sel  (mid_sel),
        .out_q    (out_code),
        .pd_hiz   (out_hiz),
        .pd_pull  (out_pulldown),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assert_frame_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> (state == ST_EXEC));

    assert_read_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(frame_valid, 2));
endmodule

// File: tb/test_dac_cmd_ctrl.sv
`timescale 1ns/1ps
module test_dac_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [23:0] frame_word = '0;
    logic        load_n = 1'b1;
    logic        clear_n = 1'b1;
    logic        mid_sel = 1'b0;
    logic [15:0] out_code;
    logic        out_hiz, out_pulldown, rd_valid;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    logic [15:0] m_pre, m_out;
    logic        m_thru, m_hiz, m_pull, m_mid;

    always #2.5 clk = ~clk;

    dac_cmd_ctrl i_dac_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_word(frame_word),
        .load_n(load_n), .clear_n(clear_n), .mid_sel(mid_sel),
        .out_code(out_code), .out_hiz(out_hiz), .out_pulldown(out_pulldown),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [15:0] def_val();
        return m_mid ? 16'h8000 : 16'h0000;
    endfunction

    function automatic logic [15:0] cfg_val();
        return {13'b0, !m_thru, m_pull, m_hiz};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic do_reset(input logic ms);
        @(negedge clk);
        rst_n = 1'b0; mid_sel = ms;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mid = ms; m_pre = def_val(); m_out = def_val();
        m_thru = 1'b0; m_hiz = 1'b0; m_pull = 1'b0;
    endtask

    // model of one frame with both pins released
    task automatic model_frame(input logic [23:0] w, output logic erv, output logic [15:0] erd);
        logic [7:0]  c;
        logic [15:0] d;
        logic        a0;
        c = w[23:16]; d = w[15:0]; a0 = (c[2:0] == 3'b000);
        erv = 1'b0; erd = '0;
        if (c == 8'h01) begin m_pre = def_val(); m_out = def_val(); end
        else if (c == 8'h18) begin if (d[0]) m_out = m_pre; end
        else if (c == 8'h28) m_thru = d[0];
        else if (c == 8'h30) begin m_pull = d[0]; m_hiz = d[8] & ~d[0]; end
        else if (c == 8'h20) begin m_pre = d; m_out = d; end
        else if (c[7:3] == 5'b00001 && a0) begin m_pre = d; if (m_thru) m_out = d; end
        else if (c[7:3] == 5'b00010 && a0) begin m_pre = d; m_out = d; end
        else if (c[7:3] == 5'b10001 && a0) begin erv = 1'b1; erd = m_pre; end
        else if (c[7:3] == 5'b10010 && a0) begin erv = 1'b1; erd = cfg_val(); end
        else if (c[7:3] == 5'b10011 && a0) begin erv = 1'b1; erd = m_out; end
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk); frame_valid = 1'b1; frame_word = w;
        @(negedge clk); frame_valid = 1'b0;
        @(negedge clk);
    endtask

    // send a frame and check read reply and outputs one cycle after execution
    task automatic frame_chk(input logic [23:0] w, input string tag);
        logic        erv;
        logic [15:0] erd;
        model_frame(w, erv, erd);
        send(w);
        check({tag, " rd_valid"}, rd_valid, erv);
        if (erv) check({tag, " rd_data"}, rd_data, erd);
        check({tag, " out_code"}, out_code, m_out);
        check({tag, " out_hiz"}, out_hiz, m_hiz);
        check({tag, " out_pulldown"}, out_pulldown, m_pull);
    endtask

    task automatic read_chk(input logic [7:0] c, input logic [15:0] exp, input string tag);
        send({c, 16'h0000});
        check({tag, " read strobe"}, rd_valid, 1'b1);
        check({tag, " read value"}, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 reset with midscale select
        do_reset(1'b1);
        @(negedge clk);
        check("R1 out_code midscale", out_code, 16'h8000);
        check("R1 hiz after reset", out_hiz, 1'b0);
        check("R1 pulldown after reset", out_pulldown, 1'b0);
        check("R1 no read strobe", rd_valid, 1'b0);
        read_chk(8'h88, 16'h8000, "R1 preload midscale");

        // R1 reset with zero select
        do_reset(1'b0);
        @(negedge clk);
        check("R1 out_code zero", out_code, 16'h0000);
        read_chk(8'h90, 16'h0004, "R1 config value");

        // R3 write-block
        frame_chk(24'h08_A5A5, "R3 write-block");
        read_chk(8'h88, 16'hA5A5, "R3 preload loaded");

        // R2 address filter and reserved codes
        frame_chk(24'h0B_1234, "R2 wrong address write");
        read_chk(8'h88, 16'hA5A5, "R2 preload untouched");
        frame_chk(24'h83_FFFF, "R2 reserved code");
        frame_chk(24'h8D_0000, "R2 wrong address read");
        frame_chk(24'h77_FFFF, "R2 unlisted code");

        // R6 software load
        frame_chk(24'h18_0000, "R6 load not selected");
        frame_chk(24'h18_0001, "R6 load selected");
        check("R6 output copied", out_code, 16'hA5A5);

        // R4 write-through
        frame_chk(24'h28_0001, "R4 enter write-through");
        read_chk(8'h90, 16'h0000, "R4 config bit2 clear");
        frame_chk(24'h08_3C3C, "R4 write-through write");
        check("R4 output follows", out_code, 16'h3C3C);
        frame_chk(24'h28_0000, "R4 back to write-block");
        read_chk(8'h90, 16'h0004, "R4 config bit2 set");

        // R5 update writes in write-block
        frame_chk(24'h10_1111, "R5 update write");
        frame_chk(24'h20_2222, "R5 broadcast write");
        check("R5 output updated", out_code, 16'h2222);

        // R9 power-down selections
        frame_chk(24'h30_0100, "R9 hiz request");
        check("R9 hiz set", out_hiz, 1'b1);
        frame_chk(24'h30_0101, "R9 both requested");
        check("R9 pulldown wins", {out_hiz, out_pulldown}, 2'b01);
        frame_chk(24'h10_4444, "R9 write during power-down");
        read_chk(8'h90, 16'h0006, "R9 config in pulldown");
        frame_chk(24'h30_0000, "R9 exit power-down");

        // R10 reads return registers and change nothing
        frame_chk(24'h08_5555, "R10 preload differs");
        read_chk(8'h98, 16'h4444, "R10 output read");
        read_chk(8'h88, 16'h5555, "R10 preload read");
        check("R10 read leaves output", out_code, 16'h4444);
        @(negedge clk);
        check("R10 strobe one cycle", rd_valid, 1'b0);

        // R7 hardware load, pass-through while held
        @(negedge clk); load_n = 1'b0;
        repeat (4) @(negedge clk);
        m_out = m_pre;
        check("R7 hardware load copy", out_code, 16'h5555);
        model_frame(24'h08_6789, frame_word[0], frame_word[15:0]);
        send(24'h08_6789);
        @(negedge clk);
        check("R7 pass-through while low", out_code, 16'h6789);
        @(negedge clk); load_n = 1'b1;
        m_out = m_pre;
        repeat (4) @(negedge clk);

        // R8 software clear
        frame_chk(24'h01_0000, "R8 clear command");
        read_chk(8'h88, 16'h0000, "R8 preload cleared");

        // R8 hardware clear with load and a frame at once
        frame_chk(24'h10_9999, "R8 setup");
        @(negedge clk); clear_n = 1'b0; load_n = 1'b0;
        repeat (4) @(negedge clk);
        send(24'h10_7777);
        @(negedge clk);
        check("R8 clear beats load and frame", out_code, 16'h0000);
        @(negedge clk); clear_n = 1'b1; load_n = 1'b1;
        repeat (4) @(negedge clk);
        m_pre = def_val(); m_out = def_val();
        read_chk(8'h88, 16'h0000, "R8 preload after clear");

        // R8 midscale clear
        do_reset(1'b1);
        frame_chk(24'h10_0123, "R8 setup mid");
        @(negedge clk); clear_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 hardware clear midscale", out_code, 16'h8000);
        @(negedge clk); clear_n = 1'b1;
        repeat (4) @(negedge clk);
        m_pre = def_val(); m_out = def_val();

        // R2 R10 random frames against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  c;
            logic [2:0]  a;
            logic [15:0] d;
            a = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
            d = 16'($urandom);
            case ($urandom_range(0, 11))
                0:  c = 8'h01;
                1:  c = 8'h18;
                2:  c = 8'h28;
                3:  c = 8'h30;
                4:  c = 8'h20;
                5:  c = {5'b00001, a};
                6:  c = {5'b00010, a};
                7:  c = {5'b10001, a};
                8:  c = {5'b10010, a};
                9:  c = {5'b10011, a};
                10: c = {5'b10000, a};
                default: c = 8'($urandom);
            endcase
            frame_chk({c, d}, "R2 R10 random frame");
        end

        summary();
    end
endmodule